// File: doc/BRIEF.md
# Look-ahead pipelined first-order recursive filter

This block is a single-pole recursive filter on a signed fixed-point sample stream, one sample per clock. The plain recursion, where each output is the input plus the pole coefficient times the previous output, closes a multiply-add loop in one cycle. Here the loop is retimed instead: the recursion is rewritten to reach back `LA` samples, with the pole coefficient raised to the power `LA`. A short feed-forward section with taps at the lower powers of the coefficient cancels the poles that the rewrite adds. The loop then holds `LA` registers, so the multiplier and the adder each get a stage of their own.

The pole coefficient is a parameter in a signed fractional format with `FRAC` fraction bits. Its powers are derived at elaboration, so no coefficient logic is built. Apart from a fixed latency, the output follows the unpipelined recursion, up to the rounding differences that the truncating arithmetic brings in.

Top module: `sla_iir`

## Requirements
- R1: A synchronous active-high `rst` clears every register in the block, and `y_out` reads 0 after the first clock edge at which `rst` is high.
- R2: One sample is accepted on every clock edge. Output sample n appears on `y_out` after the second clock edge that follows the edge capturing input sample n, which is a latency of three edges counted from that capture edge.
- R3: The coefficient powers are c0 = 2^FRAC, which stands for unity, and ck = floor(c(k-1) * POLE / 2^FRAC) for k = 1..LA.
- R4: The feed-forward value is w[n] = x[n] + sum over k = 1..LA-1 of q(ck, x[n-k]). The current sample enters with unity weight.
- R5: The recursion is y[n] = w[n] + q(cLA, y[n-LA]). Samples before the first one after reset count as zero for both x and y.
- R6: The product q(c, v) is the exact product v*c shifted right arithmetically by FRAC bits (rounding toward minus infinity), keeping the low DW bits. Every sum is kept to DW bits and wraps modulo 2^DW.
- R7: With LA = 3, POLE = 0.5 and an impulse whose amplitude is a power of two, y matches the unpipelined recursion u[n] = x[n] + q(POLE, u[n-1]) within one LSB.
- R8: With zero state, a zero input keeps the internal sums and `y_out` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | DW | Input sample, two's complement |
| y_out | output | DW | Filtered sample, two's complement |

## Verification
The bench builds two instances and drives both with the same stimulus. The first uses the default three-register loop with a pole of 0.5. Every power of that pole is exact in the coefficient format, so power-of-two impulses can be compared against the unpipelined recursion. The second uses a four-register loop with a pole of -0.75. Its products truncate on nearly every sample and its taps alternate in sign, which tests the floor-rounding, wrap-around and deeper loop paths bit for bit against the look-ahead equations.

// File: rtl/sla_pkg.sv
package sla_pkg;

    localparam int DEF_DW   = 16;
    localparam int DEF_CW   = 16;
    localparam int DEF_FRAC = 14;
    localparam int DEF_LA   = 3;
    localparam int DEF_POLE = 8192;   // 0.5 with 14 fraction bits

    // k-th power of the pole in the same fractional format, truncated per step
    function automatic longint coef_pow(input longint pole, input int k, input int frac);
        longint r;
        r = longint'(1) <<< frac;
        for (int i = 0; i < k; i++) begin
            r = (r * pole) >>> frac;
        end
        return r;
    endfunction

endpackage

// File: rtl/sla_qmul.sv
module sla_qmul #(
    parameter int DW   = sla_pkg::DEF_DW,
    parameter int CW   = sla_pkg::DEF_CW,
    parameter int FRAC = sla_pkg::DEF_FRAC
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [CW-1:0] c,
    output logic signed [DW-1:0] p
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] full;

    assign full = PW'(a) * PW'(c);
    assign p    = DW'(full >>> FRAC);

endmodule

// File: rtl/sla_fir.sv
module sla_fir #(
    parameter int DW   = sla_pkg::DEF_DW,
    parameter int CW   = sla_pkg::DEF_CW,
    parameter int FRAC = sla_pkg::DEF_FRAC,
    parameter int LA   = sla_pkg::DEF_LA,
    parameter int POLE = sla_pkg::DEF_POLE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] x_in,
    output logic signed [DW-1:0] w_out
);
    localparam int NH = LA - 1;

    logic signed [DW-1:0] hist   [NH];
    logic signed [DW-1:0] tap_p  [LA];
    logic signed [DW-1:0] prod_q [LA];
    logic signed [DW-1:0] acc;
    logic signed [DW-1:0] w_q;
    logic                 hz;

    // input history: hist[k] holds x[n-1-k]
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NH; k++) hist[k] <= '0;
        end else begin
            hist[0] <= x_in;
            for (int k = 1; k < NH; k++) hist[k] <= hist[k-1];
        end
    end

    assign tap_p[0] = x_in;

    generate
        for (genvar k = 1; k < LA; k++) begin : g_tap
            localparam logic signed [CW-1:0] CK = CW'(sla_pkg::coef_pow(POLE, k, FRAC));
            sla_qmul #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mul (
                .a (hist[k-1]),
                .c (CK),
                .p (tap_p[k])
            );
        end
    endgenerate

    // stage 1: products; stage 2: wrap-around sum
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LA; k++) prod_q[k] <= '0;
            w_q <= '0;
        end else begin
            for (int k = 0; k < LA; k++) prod_q[k] <= tap_p[k];
            w_q <= acc;
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < LA; k++) acc = acc + prod_q[k];
    end

    always_comb begin
        hz = 1'b1;
        for (int k = 0; k < NH; k++) if (hist[k] != '0) hz = 1'b0;
    end

    assign w_out = w_q;

    // R8: silent history and silent input give a zero sum two edges later
    a_r8_fir_quiet: assert property (@(posedge clk) disable iff (rst)
        (x_in == '0 && hz) |=> ##1 (w_q == '0));

    // R4: the current sample enters the sum with unity weight
    a_r4_lead_unity: assert property (@(posedge clk) disable iff (rst)
        (x_in != '0 && hz) |=> ##1 (w_q == $past(x_in, 2)));

endmodule

// File: rtl/sla_loop.sv
module sla_loop #(
    parameter int DW   = sla_pkg::DEF_DW,
    parameter int CW   = sla_pkg::DEF_CW,
    parameter int FRAC = sla_pkg::DEF_FRAC,
    parameter int LA   = sla_pkg::DEF_LA,
    parameter int POLE = sla_pkg::DEF_POLE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] w_in,
    output logic signed [DW-1:0] y_out
);
    localparam int NM = LA - 1;
    localparam logic signed [CW-1:0] CL = CW'(sla_pkg::coef_pow(POLE, LA, FRAC));

    logic signed [DW-1:0] y_q;
    logic signed [DW-1:0] m_next;
    logic signed [DW-1:0] mpipe [NM];
    logic                 mz;

    sla_qmul #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_fb (
        .a (y_q),
        .c (CL),
        .p (m_next)
    );

    // adder stage writes y_q; multiplier stage feeds mpipe; LA registers in loop
    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
            for (int k = 0; k < NM; k++) mpipe[k] <= '0;
        end else begin
            y_q      <= w_in + mpipe[NM-1];
            mpipe[0] <= m_next;
            for (int k = 1; k < NM; k++) mpipe[k] <= mpipe[k-1];
        end
    end

    always_comb begin
        mz = 1'b1;
        for (int k = 0; k < NM; k++) if (mpipe[k] != '0) mz = 1'b0;
    end

    assign y_out = y_q;

    // R8: empty loop with zero drive stays at zero
    a_r8_loop_quiet: assert property (@(posedge clk) disable iff (rst)
        (w_in == '0 && y_q == '0 && mz) |=> (y_q == '0));

    // R5: with an empty loop the first output equals the drive
    a_r5_loop_first: assert property (@(posedge clk) disable iff (rst)
        (w_in != '0 && y_q == '0 && mz) |=> (y_q == $past(w_in)));

endmodule

// File: rtl/sla_iir.sv
module sla_iir #(
    parameter int DW   = sla_pkg::DEF_DW,
    parameter int CW   = sla_pkg::DEF_CW,
    parameter int FRAC = sla_pkg::DEF_FRAC,
    parameter int LA   = sla_pkg::DEF_LA,
    parameter int POLE = sla_pkg::DEF_POLE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] x_in,
    output logic signed [DW-1:0] y_out
);
    logic signed [DW-1:0] w_mid;

    sla_fir #(.DW(DW), .CW(CW), .FRAC(FRAC), .LA(LA), .POLE(POLE)) u_fir (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .w_out (w_mid)
    );

    sla_loop #(.DW(DW), .CW(CW), .FRAC(FRAC), .LA(LA), .POLE(POLE)) u_loop (
        .clk   (clk),
        .rst   (rst),
        .w_in  (w_mid),
        .y_out (y_out)
    );

    // R1: reset clears the output on the next edge
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (y_out == '0));

endmodule

// File: tb/sim_sla_iir.sv
module sim_sla_iir;
    localparam int CLK_NS = 10;
    localparam int FR     = 14;
    localparam int LAT    = 3;
    localparam int P0     = 8192;     // 0.5
    localparam int L0     = 3;
    localparam int P1     = -12288;   // -0.75
    localparam int L1     = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] x = '0;
    logic signed [15:0] y0, y1;

    int total = 0;
    int bad   = 0;
    int xs [64];
    int e0 [64];
    int e1 [64];
    int ef [64];

    always #(CLK_NS/2) clk = ~clk;

    sla_iir #(.LA(L0), .POLE(P0)) u0 (.clk(clk), .rst(rst), .x_in(x), .y_out(y0));
    sla_iir #(.LA(L1), .POLE(P1)) u1 (.clk(clk), .rst(rst), .x_in(x), .y_out(y1));

    function automatic int wrap16(input longint v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int mulq(input longint v, input longint c);
        return wrap16((v * c) >>> FR);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 R4 R5 R6: look-ahead equations
    task automatic calc_la(input int pole, input int la, input int n, output int ey [64]);
        longint c [8];
        c[0] = longint'(1) <<< FR;
        for (int k = 1; k <= la; k++) c[k] = (c[k-1] * pole) >>> FR;
        for (int i = 0; i < 64; i++) begin
            int w;
            int xv;
            xv = (i < n) ? xs[i] : 0;
            w = xv;
            for (int k = 1; k < la; k++)
                if (i - k >= 0 && i - k < n) w = w + mulq(xs[i-k], c[k]);
            w = wrap16(w);
            ey[i] = wrap16(w + ((i - la >= 0) ? mulq(ey[i-la], c[la]) : 0));
        end
    endtask

    // R7: unpipelined recursion
    task automatic calc_flat(input int pole, input int n, output int ey [64]);
        for (int i = 0; i < 64; i++) begin
            int xv;
            xv = (i < n) ? xs[i] : 0;
            ey[i] = wrap16(xv + ((i > 0) ? mulq(ey[i-1], pole) : 0));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x   = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_seq(input string tag, input int n, input bit flat);
        calc_la(P0, L0, n, e0);
        calc_la(P1, L1, n, e1);
        calc_flat(P0, n, ef);
        do_reset();
        for (int m = 0; m < n + 12 + LAT; m++) begin
            if (m >= LAT) begin
                chk({tag, " u0"}, int'(y0), e0[m-LAT]);
                chk({tag, " u1"}, int'(y1), e1[m-LAT]);
                if (flat) begin
                    int d;
                    d = int'(y0) - ef[m-LAT];
                    total++;
                    if (d > 1 || d < -1) begin
                        bad++;
                        $display("FAIL R7 actual=%0d expected=%0d", int'(y0), ef[m-LAT]);
                    end
                end
            end
            x = (m < n) ? 16'(xs[m]) : '0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        // R1: garbage history then reset
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            x = 16'(1000 * (i + 1));
            @(negedge clk);
        end
        rst = 1'b1;
        x   = 16'sd7000;
        @(negedge clk);
        chk("R1 u0", int'(y0), 0);
        chk("R1 u1", int'(y1), 0);
        // R8: zero input, zero state stays silent
        rst = 1'b0;
        x   = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R8 u0", int'(y0), 0);
            chk("R8 u1", int'(y1), 0);
        end
    endtask

    task automatic t_latency();
        // R2: first output only after three capture edges
        do_reset();
        x = 16'sd2048;
        @(negedge clk);
        x = '0;
        chk("R2 edge1", int'(y0), 0);
        @(negedge clk);
        chk("R2 edge2", int'(y0), 0);
        @(negedge clk);
        chk("R2 edge3", int'(y0), 2048);
        chk("R2 edge3 u1", int'(y1), 2048);
    endtask

    task automatic t_impulse_pos();
        for (int i = 0; i < 64; i++) xs[i] = 0;
        xs[0] = 1024;
        run_seq("R4 R5 R7 impulse+", 1, 1'b1);
    endtask

    task automatic t_impulse_neg();
        xs[0] = -1024;
        run_seq("R4 R5 R7 impulse-", 1, 1'b1);
    endtask

    task automatic t_step();
        for (int i = 0; i < 24; i++) xs[i] = 5000;
        run_seq("R3 R5 step", 24, 1'b0);
    endtask

    task automatic t_alt();
        for (int i = 0; i < 24; i++) xs[i] = (i % 2 == 0) ? 3001 : -2999;
        run_seq("R3 R6 alternating", 24, 1'b0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 16; i++) xs[i] = 30000 - i * 7;
        run_seq("R6 wrap", 16, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_impulse_pos();
        t_impulse_neg();
        t_step();
        t_alt();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule